// File: doc/BRIEF.md
# Reconfigurable Bit-Serial Tree Broadcast Switch

This block is one bit-serial broadcast tree that links a row of leaf ports, one per compute or memory tile. Each leaf has a transmit-select and a one-bit data input. Every internal joint of the binary tree holds a switch point that either joins its two child subtrees or keeps them apart. A leaf that is selected puts its bit onto the tree each cycle. The tree delivers that bit to every leaf of the connected region the source sits in, and that includes the source itself.

With every joint closed the block is one global broadcast tree. If the upper joints are opened, the tree splits into independent local subtrees. These subtrees carry traffic in parallel, and each has a shorter pipeline than the whole tree. Every tree level holds one register stage, both on the way up to the region's top joint and on the way back down to the leaves. The joint settings are held in a configuration register. That register accepts a new setting only while the tree carries no traffic.

Within one region only one leaf should transmit. If more than one does, the lowest-indexed leaf wins and a conflict flag is raised.

Top module: `sw_tree_bcast`

## Requirements
- R1: Reset state.
  - After reset all `rx_valid_o` and `rx_data_o` bits are 0 and `conflict_o` is 0.
  - The stored configuration is global mode.
- R2: Joint numbering and configuration load.
  - Internal tree nodes are numbered in heap order. Node 1 is the root, the children of node k are 2k and 2k+1, and leaf i is node LEAVES+i.
  - Bit j of `cfg_join_i` controls node j+1. A value of 1 closes the joint, which joins its two subtrees.
  - A `cfg_load_i` pulse in an idle cycle stores `cfg_global_i` and `cfg_join_i`. A cycle is idle when no transmit-select is asserted and no valid bit is inside the tree.
- R3: A `cfg_load_i` pulse in a busy cycle is ignored. This covers a cycle with a transmit-select asserted and a cycle in which data is still draining through the tree. The old partition stays in force.
- R4: Global mode.
  - With `cfg_global_i`=1 stored, every joint is closed, whatever the joint vector holds.
  - One source bit reaches all LEAVES leaves, the source included, 2*log2(LEAVES) cycles after it is driven (8 for 16 leaves).
  - Successive bits arrive in their original order.
- R5: Local mode latency.
  - With global mode off, a leaf belongs to the region rooted at the highest ancestor reached through closed joints only.
  - A bit reaches the leaves of that region 2h cycles after it is driven, where h is the height of the region's root above the leaves.
- R6: Regions that are separated by an open joint carry different sources in the same cycles, without interference and without raising `conflict_o`.
- R7: A leaf receives `rx_valid_o`=0 and `rx_data_o`=0 when its parent joint is open, and also when its region has no selected source.
- R8: Conflict handling.
  - When two or more selected leaves meet at a closed joint, the leaf in the lower-indexed (left) subtree wins.
  - `conflict_o` is 1 one cycle after the competing bits meet at that joint, and stays 1 while they persist.
- R9: The `tx_data_i` bit of a leaf whose `tx_sel_i` is 0 has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock, one serial bit per cycle |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_load_i | input | 1 | Request to store the configuration inputs |
| cfg_global_i | input | 1 | 1 = global mode, all joints closed |
| cfg_join_i | input | LEAVES-1 | Per-joint close bits, bit j for heap node j+1 |
| tx_sel_i | input | LEAVES | Per-leaf transmit-select for this tree |
| tx_data_i | input | LEAVES | Per-leaf serial data bit |
| rx_valid_o | output | LEAVES | Per-leaf received-bit valid |
| rx_data_o | output | LEAVES | Per-leaf received serial bit, 0 when not valid |
| conflict_o | output | 1 | Two or more sources met in one region |

## Verification
A configuration load can arrive in the same cycle as live serial traffic. This happens when a load is pulsed while a leaf transmits, or in the cycle right after transmit-select drops while bits are still moving down the tree. The bench provokes both cases. It then streams again without a new load and judges the result at the ports: the old local partition must still hold, with the upper half silent and the lower half receiving after the local latency. Arbitration and delivery also coincide. Two sources in one region are streamed with bit patterns that differ, and the received bits must match the lower-indexed source in the same cycles that the conflict flag is high.

// File: rtl/sw_tree_pkg.sv
package sw_tree_pkg;
  typedef struct packed {
    logic v;
    logic d;
  } sbit_t;
endpackage

// File: rtl/sw_cfg_reg.sv
module sw_cfg_reg #(
  parameter int NODES = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             idle_i,
  input  logic             global_i,
  input  logic [NODES-1:0] join_i,
  output logic [NODES-1:0] closed_o
);
  logic             global_q;
  logic [NODES-1:0] join_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      global_q <= 1'b1;
      join_q   <= '1;
    end else if (load_i && idle_i) begin
      global_q <= global_i;
      join_q   <= join_i;
    end
  end

  assign closed_o = global_q ? '1 : join_q;

  AST_CFG_FROZEN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idle_i |=> ($stable(join_q) && $stable(global_q))); // R3
endmodule

// File: rtl/sw_merge_node.sv
module sw_merge_node
  import sw_tree_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  closed_i,
  input  sbit_t l_i,
  input  sbit_t r_i,
  output sbit_t up_o,
  output logic  conflict_o
);
  sbit_t up_q;

  // left subtree holds the lower leaf indices, so it wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      up_q <= '0;
    end else begin
      up_q.v <= closed_i & (l_i.v | r_i.v);
      up_q.d <= closed_i & (l_i.v ? l_i.d : (r_i.v & r_i.d));
    end
  end

  assign up_o       = up_q;
  assign conflict_o = closed_i & l_i.v & r_i.v;

  AST_LEFT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (closed_i && l_i.v && r_i.v) |=> (up_o.v && (up_o.d == $past(l_i.d)))); // R8
endmodule

// File: rtl/sw_bcast_stage.sv
module sw_bcast_stage
  import sw_tree_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  pass_i,
  input  sbit_t src_i,
  output sbit_t q_o
);
  sbit_t q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q <= '0;
    end else begin
      q_q.v <= pass_i & src_i.v;
      q_q.d <= pass_i & src_i.v & src_i.d;
    end
  end

  assign q_o = q_q;
endmodule

// File: rtl/sw_tree_bcast.sv
module sw_tree_bcast
  import sw_tree_pkg::*;
#(
  parameter int LEAVES = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_load_i,
  input  logic              cfg_global_i,
  input  logic [LEAVES-2:0] cfg_join_i,
  input  logic [LEAVES-1:0] tx_sel_i,
  input  logic [LEAVES-1:0] tx_data_i,
  output logic [LEAVES-1:0] rx_valid_o,
  output logic [LEAVES-1:0] rx_data_o,
  output logic              conflict_o
);
  localparam int LVL   = $clog2(LEAVES);
  localparam int NODES = LEAVES - 1;
  localparam int HEAP  = 2 * LEAVES;

  initial assert (LEAVES == (1 << LVL)) else $error("LEAVES must be a power of two");

  logic [NODES-1:0]  join_eff;
  logic [LEAVES-1:1] closed;
  logic [LEAVES-1:1] node_conf;
  logic              busy;
  logic              conflict_q;

  sbit_t up_s [1:HEAP-1];
  sbit_t dn_s [2:HEAP-1];
  sbit_t bc_s [1:LEAVES-1];

  sw_cfg_reg #(.NODES(NODES)) i_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (cfg_load_i),
    .idle_i   (!busy),
    .global_i (cfg_global_i),
    .join_i   (cfg_join_i),
    .closed_o (join_eff)
  );

  assign closed = join_eff;

  for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
    assign up_s[LEAVES+i] = '{v: tx_sel_i[i], d: tx_sel_i[i] & tx_data_i[i]};
    assign rx_valid_o[i]  = dn_s[LEAVES+i].v;
    assign rx_data_o[i]   = dn_s[LEAVES+i].d;
  end

  for (genvar k = 1; k < LEAVES; k++) begin : g_node
    sw_merge_node i_merge (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .closed_i   (closed[k]),
      .l_i        (up_s[2*k]),
      .r_i        (up_s[2*k+1]),
      .up_o       (up_s[k]),
      .conflict_o (node_conf[k])
    );
    // region root turns the upward value around; inner nodes relay the parent
    if (k == 1) begin : g_root
      assign bc_s[k] = closed[k] ? up_s[k] : '0;
    end else begin : g_inner
      assign bc_s[k] = !closed[k] ? '0 : (closed[k/2] ? dn_s[k] : up_s[k]);
    end
  end

  for (genvar n = 2; n < HEAP; n++) begin : g_down
    sw_bcast_stage i_stage (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pass_i (closed[n/2]),
      .src_i  (bc_s[n/2]),
      .q_o    (dn_s[n])
    );
  end

  always_comb begin
    busy = |tx_sel_i;
    for (int k = 1; k < LEAVES; k++) busy = busy | up_s[k].v;
    for (int n = 2; n < HEAP; n++)   busy = busy | dn_s[n].v;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) conflict_q <= 1'b0;
    else         conflict_q <= |node_conf;
  end

  assign conflict_o = conflict_q;

  AST_GLOBAL_UNIFORM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&closed) |-> ((rx_valid_o == '0) || (rx_valid_o == '1))); // R4

  for (genvar m = 0; m < LEAVES/2; m++) begin : g_pair_chk
    AST_PAIR_AGREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(closed[LEAVES/2+m]) |-> ((rx_valid_o[2*m] == rx_valid_o[2*m+1]) &&
                                     (rx_data_o[2*m] == rx_data_o[2*m+1]))); // R5
    AST_ISO_LEAF_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$past(closed[LEAVES/2+m]) |-> (!rx_valid_o[2*m] && !rx_valid_o[2*m+1])); // R7
  end
endmodule

// File: tb/test_sw_tree_bcast.sv
module test_sw_tree_bcast;
  localparam int N = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cfg_load_i = 1'b0;
  logic          cfg_global_i = 1'b0;
  logic [N-2:0]  cfg_join_i = '0;
  logic [N-1:0]  tx_sel_i = '0;
  logic [N-1:0]  tx_data_i = '0;
  logic [N-1:0]  rx_valid_o;
  logic [N-1:0]  rx_data_o;
  logic          conflict_o;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk_i = ~clk_i;

  sw_tree_bcast #(.LEAVES(N)) i_sw_tree_bcast (.*);

  typedef struct packed {
    logic        glob;
    logic [14:0] join_v;
    logic [15:0] tx;
    logic [15:0] exp_v;
    logic [3:0]  lat;
    logic        conf;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{1'b1, 15'h0000, 16'h0020, 16'hFFFF, 4'd8, 1'b0}, // R4 global, leaf 5
    '{1'b0, 15'h7FFE, 16'h1004, 16'hFFFF, 4'd6, 1'b0}, // R6 halves, leaves 2 and 12
    '{1'b0, 15'h7FF8, 16'h0842, 16'h0FFF, 4'd4, 1'b0}, // R5 quarters, last empty
    '{1'b0, 15'h7F80, 16'h0209, 16'h030F, 4'd2, 1'b0}, // R5 pairs
    '{1'b0, 15'h0000, 16'hFFFF, 16'h0000, 4'd0, 1'b0}, // R7 all isolated
    '{1'b1, 15'h0000, 16'h0208, 16'hFFFF, 4'd8, 1'b1}, // R8 global, 3 vs 9
    '{1'b0, 15'h7FFE, 16'h0050, 16'h00FF, 4'd6, 1'b1}  // R8 halves, 4 vs 6
  };

  function automatic string tag_of(int v);
    case (v)
      0: return "R4 global single source";
      1: return "R6 parallel halves";
      2: return "R5 R2 quarter regions";
      3: return "R5 pair regions";
      4: return "R7 isolated leaves";
      5: return "R8 global conflict";
      default: return "R8 local conflict";
    endcase
  endfunction

  function automatic logic pat(int i, int s);
    return (((i >> (s % 4)) ^ (s / 3)) & 1) == 1;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic run_stream(logic [15:0] tx, logic [15:0] ev, int lat, logic conf, string tag);
    for (int s = 0; s < 24; s++) begin
      if ((lat > 0 && s >= lat && s < lat + 8) || (lat == 0 && s >= 1 && s <= 8)) begin
        logic [15:0] ed;
        ed = '0;
        for (int j = 0; j < N; j++) begin
          if (ev[j]) begin
            int h;
            int drv;
            h = lat / 2;
            drv = -1;
            for (int i = N - 1; i >= 0; i--)
              if (tx[i] && ((i >> h) == (j >> h))) drv = i;
            if (drv >= 0) ed[j] = pat(drv, s - lat);
          end
        end
        check({tag, " valid"}, 32'(rx_valid_o), 32'(ev));
        check({tag, " data"}, 32'(rx_data_o), 32'(ed));
      end
      tx_sel_i = tx;
      for (int i = 0; i < N; i++) tx_data_i[i] = pat(i, s);
      @(negedge clk_i);
    end
    check({tag, " conflict"}, 32'(conflict_o), 32'(conf));
    tx_sel_i = '0;
  endtask

  task automatic run_vec(int v);
    tx_sel_i = '0;
    repeat (12) @(negedge clk_i);
    cfg_global_i = VECS[v].glob;
    cfg_join_i   = VECS[v].join_v;
    cfg_load_i   = 1'b1;
    @(negedge clk_i);
    cfg_load_i   = 1'b0;
    run_stream(VECS[v].tx, VECS[v].exp_v, int'(VECS[v].lat), VECS[v].conf, tag_of(v));
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog act=running exp=done");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 reset valid", 32'(rx_valid_o), 32'h0);
    check("R1 reset data", 32'(rx_data_o), 32'h0);
    check("R1 reset conflict", 32'(conflict_o), 32'h0);
    // reset configuration must be global
    run_stream(16'h0001, 16'hFFFF, 8, 1'b0, "R1 default global");
    repeat (12) @(negedge clk_i);
    // unselected leaves toggle data but must stay silent
    run_stream(16'h0000, 16'h0000, 0, 1'b0, "R9 unselected data");

    for (int v = 0; v < 7; v++) run_vec(v);

    // R3: load while transmitting, then load while the tree drains
    repeat (12) @(negedge clk_i);
    tx_sel_i = 16'h0010;
    repeat (3) @(negedge clk_i);
    cfg_global_i = 1'b1;
    cfg_join_i   = '1;
    cfg_load_i   = 1'b1;
    @(negedge clk_i);
    tx_sel_i     = '0;
    @(negedge clk_i);
    cfg_load_i   = 1'b0;
    repeat (12) @(negedge clk_i);
    run_stream(16'h0010, 16'h00FF, 6, 1'b0, "R3 busy load ignored");
    finish_run();
  end
endmodule